// File: doc/BRIEF.md
# Half-Multiplier Symmetric Transposed FIR Sub-Filter

This block is a single-rate FIR filter for coefficient sets that mirror about their centre. The mirror is either even (tap `TAPS-1-k` equals tap `k`) or odd (tap `TAPS-1-k` equals minus tap `k`). Only the first half of the coefficients is stored and multiplied. Each of the `TAPS/2` products is fed into two positions of a transposed adder-register chain. In odd mode the product is subtracted at the mirrored position. The block is intended as the summed or differenced sub-filter inside a larger parallel fast-FIR arrangement. In such an arrangement the summed half-band of an even-symmetric prototype has even symmetry, and the differenced one has odd symmetry.

Samples enter on a valid/ready stream and results leave on a second valid/ready stream. A sample is accepted when `in_valid && in_ready`. `in_ready` is high whenever the output holding register is empty or is being emptied in the same cycle. When the consumer holds `out_ready` low with a result pending, the result stays put and `in_ready` drops. The filter history therefore never moves while the output is blocked. The coefficients, the tap count and the mirror mode are elaboration-time parameters.

Top module: `fir_sym_tap`

## Requirements
- R1: For every accepted sample x[n], the result equals the sum over k of tap(k)·x[n-k] over the last `TAPS` accepted samples, with missing history taken as zero. Here tap(k) is coefficient k for k < TAPS/2. In even mode (`ANTI`=0), tap(k) for k ≥ TAPS/2 is coefficient TAPS-1-k.
- R2: With `ANTI`=1, tap(k) for k ≥ TAPS/2 is the negative of coefficient TAPS-1-k.
- R3: `out_data` is `DATA_W+COEF_W+$clog2(TAPS)` bits wide and signed, and results stay exact at full-scale inputs and coefficients. This includes a coefficient of -2^(COEF_W-1) whose mirror is +2^(COEF_W-1).
- R4: The result for a sample accepted at a clock edge is on `out_data`, with `out_valid` high, right after that edge.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` holds its value and `in_ready` is low.
- R6: The filter history advances only on accepted samples. Cycles without acceptance leave the history and `out_data` unchanged.
- R7: An active-low `rst_n` clears the history, `out_valid` and `out_data`.
- R8: `in_ready` is high when `out_valid` is low or `out_ready` is high. When a result is taken with no new sample accepted, `out_valid` goes low after the edge.
- R9: Coefficient i (signed, i < TAPS/2) sits at bits [i*COEF_W +: COEF_W] of the `COEFS` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | DATA_W+COEF_W+$clog2(TAPS) | Signed filter result |

## Verification
The assertions assume that the producer and consumer follow ordinary valid/ready use. They do not assume that `in_valid` stays high until it is accepted, because the block places no such demand. They also assume that reset is held for at least one edge before traffic starts. The stimulus drives `in_valid`, `in_data` and `out_ready` only between clock edges. Reset is held with `in_valid` low. The bench drops samples that are refused, and tracks the expected history from accepted samples only, so refused samples never enter the reference.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

  typedef enum logic {
    MIRROR_EVEN = 1'b0,
    MIRROR_ODD  = 1'b1
  } mirror_e;

  function automatic int acc_width(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction

  // Mirror source: which stored product serves chain tap t
  function automatic int src_of(input int t, input int taps);
    return (t < taps / 2) ? t : (taps - 1 - t);
  endfunction

endpackage

// File: rtl/fir_sym_mult_bank.sv
module fir_sym_mult_bank #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int HALF   = 6,
  parameter logic [HALF*COEF_W-1:0] COEFS = '0
) (
  input  logic [DATA_W-1:0]               x,
  output logic [HALF*(DATA_W+COEF_W)-1:0] prod_flat
);
  localparam int PW = DATA_W + COEF_W;

  for (genvar i = 0; i < HALF; i++) begin : g_mul
    localparam logic signed [COEF_W-1:0] CI = COEFS[i*COEF_W +: COEF_W];
    logic signed [PW-1:0] p;
    assign p = PW'($signed(x)) * PW'(CI);
    assign prod_flat[i*PW +: PW] = p;
  end
endmodule

// File: rtl/fir_sym_chain.sv
module fir_sym_chain
  import fir_sym_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 12,
  parameter mirror_e MODE = MIRROR_EVEN,
  parameter int ACC_W  = acc_width(DATA_W, COEF_W, TAPS)
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      adv,
  input  logic [(TAPS/2)*(DATA_W+COEF_W)-1:0]       prod_flat,
  output logic signed [ACC_W-1:0]                   y_now
);
  localparam int HALF = TAPS / 2;
  localparam int PW   = DATA_W + COEF_W;
  localparam int NREG = TAPS - 1;

  logic signed [ACC_W-1:0] pext [HALF];
  logic signed [ACC_W-1:0] st   [NREG];

  for (genvar i = 0; i < HALF; i++) begin : g_ext
    assign pext[i] = {{(ACC_W-PW){prod_flat[i*PW+PW-1]}}, prod_flat[i*PW +: PW]};
  end

  // Stage j holds the partial sum that will meet tap j+1
  for (genvar j = 0; j < NREG; j++) begin : g_stage
    localparam int T   = j + 1;
    localparam int SRC = src_of(T, TAPS);
    logic signed [ACC_W-1:0] term;
    logic signed [ACC_W-1:0] upstream;

    if (T >= HALF && MODE == MIRROR_ODD) begin : g_neg
      assign term = -pext[SRC];
    end else begin : g_pos
      assign term = pext[SRC];
    end

    if (j == NREG - 1) begin : g_tail
      assign upstream = '0;
    end else begin : g_link
      assign upstream = st[j+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) st[j] <= '0;
      else if (adv) st[j] <= term + upstream;
    end
  end

  assign y_now = pext[0] + st[0];
endmodule

// File: rtl/fir_sym_out_stage.sv
module fir_sym_out_stage #(
  parameter int ACC_W = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic                    take,
  input  logic signed [ACC_W-1:0] y_now,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [ACC_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= y_now;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fir_sym_tap.sv
module fir_sym_tap
  import fir_sym_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 12,
  parameter mirror_e MODE = MIRROR_EVEN,
  parameter logic [(TAPS/2)*COEF_W-1:0] COEFS = {
    16'sd333, -16'sd15321, 16'sd20000, -16'sd7, 16'sd1201, -16'sd32768},
  localparam int ACC_W = acc_width(DATA_W, COEF_W, TAPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DATA_W-1:0]       in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ACC_W-1:0]        out_data
);
  localparam int HALF = TAPS / 2;
  localparam int PW   = DATA_W + COEF_W;

  logic [HALF*PW-1:0]      prod_flat;
  logic signed [ACC_W-1:0] y_now;
  logic signed [ACC_W-1:0] res_q;
  logic                    take;

  fir_sym_mult_bank #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .HALF(HALF), .COEFS(COEFS)
  ) u_mul (
    .x(in_data), .prod_flat(prod_flat)
  );

  fir_sym_chain #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .MODE(MODE), .ACC_W(ACC_W)
  ) u_chain (
    .clk(clk), .rst_n(rst_n), .adv(take), .prod_flat(prod_flat), .y_now(y_now)
  );

  fir_sym_out_stage #(.ACC_W(ACC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .take(take), .y_now(y_now), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(res_q)
  );

  assign out_data = res_q;
endmodule

// File: rtl/fir_sym_tap_chk.sv
module fir_sym_tap_chk #(
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data
);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_data));

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_empty_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind fir_sym_tap fir_sym_tap_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_fir_sym_tap.sv
`timescale 1ns/100ps
module tb_fir_sym_tap;
  import fir_sym_pkg::*;

  localparam int DW = 16, CW = 16, TAPS = 12, HALF = TAPS / 2;
  localparam int AW = DW + CW + $clog2(TAPS);

  // Coefficient i at bits [i*16 +: 16] (R9)
  localparam logic [HALF*CW-1:0] CS_EVEN =
    {16'h014D, 16'hC427, 16'h4E20, 16'hFFF9, 16'h04B1, 16'h8000};
  localparam logic [HALF*CW-1:0] CS_ODD =
    {16'h1234, 16'h8000, 16'hFFFF, 16'h270F, 16'hF800, 16'h7FFF};
  int sc[HALF] = '{-32768, 1201, -7, 20000, -15321, 333};
  int ac[HALF] = '{32767, -2048, 9999, -1, -32768, 4660};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, in_ready_o, out_valid, out_valid_o;
  logic [AW-1:0] out_data, out_data_o;

  always #2 clk = ~clk;

  fir_sym_tap #(.TAPS(TAPS), .MODE(MIRROR_EVEN), .COEFS(CS_EVEN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  fir_sym_tap #(.TAPS(TAPS), .MODE(MIRROR_ODD), .COEFS(CS_ODD)) dut_odd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_o),
    .in_data(in_data), .out_valid(out_valid_o), .out_ready(out_ready),
    .out_data(out_data_o));

  int checks = 0, fails = 0;
  bit done = 0;
  longint hist[TAPS];
  longint exp_e = 0, exp_o = 0;

  function automatic longint tap_of(int k, bit odd);
    if (k < HALF) return odd ? longint'(ac[k]) : longint'(sc[k]);
    return odd ? -longint'(ac[TAPS-1-k]) : longint'(sc[TAPS-1-k]);
  endfunction

  function automatic longint conv(bit odd);
    longint s = 0;
    for (int k = 0; k < TAPS; k++) s += tap_of(k, odd) * hist[k];
    return s;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint sx(logic [AW-1:0] v);
    return longint'($signed(v));
  endfunction

  // Called just after a falling edge; returns just after the next one.
  task automatic step(bit v, logic signed [DW-1:0] d, bit rdy, string req);
    bit acc, was;
    in_valid = v; in_data = d; out_ready = rdy;
    #0.5;
    acc = v && in_ready;
    was = out_valid;
    chk(in_ready == in_ready_o, {req, " ready match"}, in_ready_o, in_ready);
    @(posedge clk);
    if (acc) begin
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(d);
      exp_e = conv(0);
      exp_o = conv(1);
    end
    #1;
    if (acc) begin
      chk(out_valid && out_valid_o, {req, " valid"}, out_valid, 1);
      chk(sx(out_data) == exp_e, {req, " even"}, sx(out_data), exp_e);
      chk(sx(out_data_o) == exp_o, {req, " odd"}, sx(out_data_o), exp_o);
    end else if (was && !rdy) begin
      chk(out_valid == 1 && in_ready == 0, "R5 hold", out_valid, 1);
      chk(sx(out_data) == exp_e, "R5 held data", sx(out_data), exp_e);
    end else begin
      chk(out_valid == 0 && out_valid_o == 0, "R8 drained", out_valid, 0);
      chk(sx(out_data_o) == exp_o, "R6 unchanged", sx(out_data_o), exp_o);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; out_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    exp_e = 0; exp_o = 0;
    #0.5;
    chk(out_valid == 0 && out_valid_o == 0, "R7 valid cleared", out_valid, 0);
    chk(sx(out_data) == 0 && sx(out_data_o) == 0, "R7 data cleared", sx(out_data), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5EED_0017;
    void'($urandom(seed));
    @(negedge clk);
    do_reset();

    // R1 R2 R9: impulse response exposes every tap and its mirror
    step(1, 16'sd1, 1, "R1 R9 impulse");
    for (int i = 0; i < TAPS; i++) step(1, 16'sd0, 1, "R2 impulse tail");

    // R6: gaps without valid leave history alone
    step(1, 16'sd700, 1, "R6 pre-gap");
    for (int i = 0; i < 3; i++) step(0, 16'sd31000, 1, "R6 gap");
    step(1, -16'sd45, 1, "R6 post-gap");

    // R5 R8: blocked output, then take-and-accept in one cycle, then drain
    step(1, 16'sd123, 0, "R4 load");
    step(1, 16'sd9999, 0, "R5 refused");
    step(1, 16'sd9999, 0, "R5 refused again");
    step(1, -16'sd321, 1, "R8 swap");
    step(0, 16'sd0, 1, "R8 drain");

    // R3: full-scale stress
    for (int i = 0; i < TAPS; i++) step(1, -16'sd32768, 1, "R3 min");
    for (int i = 0; i < TAPS; i++)
      step(1, (i % 2) ? 16'sd32767 : -16'sd32768, 1, "R3 alt");

    // Constrained random traffic
    for (int i = 0; i < 400; i++) begin
      logic [DW-1:0] r = DW'($urandom);
      bit v = ($urandom % 4) != 0;
      bit rd = ($urandom % 5) != 0;
      step(v, r, rd, "R1 random");
    end

    // R7: reset mid-stream wipes history
    step(1, 16'sd5000, 1, "R7 pre");
    do_reset();
    step(1, 16'sd2, 1, "R7 post impulse");
    for (int i = 0; i < 3; i++) step(1, 16'sd0, 1, "R7 post tail");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule